// File: doc/BRIEF.md
# Two-Wire Debug Command Slave

This block is the target end of a two-wire serial debug link made of one clock input from the host and one data pin that carries data both ways. The host opens the link by pulsing the debug clock exactly twice while the chip reset pin is held low. After that, each command starts with one byte. Its top five bits name the operation, one bit asks for a reply, and the two low bits say how many argument bytes follow. The block shifts in the whole command. It hands permitted commands to an abstract back-end through a one-cycle request strobe, and it shifts one reply byte back out to the host when the command asked for one.

Both pins are oversampled by the system clock through a synchronizer chain, and all edge detection works on the synchronized copies. The debug clock must therefore run at no more than a quarter of the system clock rate. A debug-lock input, active low, cuts the accepted operations down to three whitelisted codes. Blocked and unknown commands still use up all their argument bytes. If such a command asked for a reply, it gets a zero reply, so host and target stay aligned on byte boundaries.

The controller has six states:
- `S_OFF`: the link is closed.
- `S_ARM`: the chip reset pin is low and rising edges are being counted.
- `S_CMD`: the command byte is being received.
- `S_ARG`: argument bytes are being received.
- `S_ISSUE`: one cycle in which the request is made.
- `S_RESP`: the reply byte is being driven.

Transitions:
- `S_OFF` → `S_ARM` when the reset pin goes low.
- `S_ARM` → `S_CMD` on reset release if exactly two edges were counted.
- `S_ARM` → `S_OFF` on reset release otherwise.
- `S_CMD` → `S_ARG` or `S_ISSUE` after the eighth bit, depending on the argument count.
- `S_ARG` → `S_ISSUE` after the last argument bit.
- `S_ISSUE` → `S_RESP` or `S_CMD`, depending on the reply flag.
- `S_RESP` → `S_CMD` after the eighth reply bit.
- Any of `S_CMD`, `S_ARG`, `S_ISSUE` or `S_RESP` → `S_ARM` when the reset pin goes low.

Top module: `dbg_link_slave`

## Requirements
- R1: The link opens only when exactly two rising debug-clock edges occur while `chip_rst_n_pin` is low, followed by its release. One edge or three edges leave the link closed.
- R2: While the link is closed, `ddata_oe` stays low and `req_valid` never pulses, whatever the pins do.
- R3: A new low phase of `chip_rst_n_pin` with no debug-clock edges closes an open link.
- R4: The command byte decodes as follows: bits 7..3 are the operation code, bit 2 set requests a reply byte, and bits 1..0 give the argument count 0..3. `req_code` and `req_nargs` carry the code and the count.
- R5: Bits are sampled on falling debug-clock edges, most significant bit first. `req_args` holds the argument bytes in the low 8·n bits, with the first byte received the most significant of them. It is zero when n is 0.
- R6: The reply byte is shifted out most significant bit first, changing only after rising debug-clock edges. `ddata_oe` is high only while it is shifted and falls after the eighth falling edge.
- R7: When `dbg_lock_bit` is 0, only codes 5'h02, 5'h06 and 5'h0C produce a request. When it is 1, code 5'h0B produces a request as well.
- R8: A blocked or unknown code (anything other than 5'h02, 5'h06, 5'h0B, 5'h0C) still consumes its argument bytes, produces no request, and replies 8'h00 if bit 2 was set.
- R9: The reply to code 5'h06 has bit 0 equal to `dbg_lock_bit` and bits 7..1 taken from `rsp_data`.
- R10: Each permitted command produces exactly one single-cycle `req_valid` pulse. `rsp_data` is taken in that same cycle as the reply for codes other than 5'h06.
- R11: When bit 2 of the command byte is clear, `ddata_oe` stays low for the whole command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Block reset, active low |
| chip_rst_n_pin | input | 1 | Chip reset pin, active low, observed asynchronously |
| dclk_pin | input | 1 | Debug clock from the host, asynchronous |
| ddata_in | input | 1 | Level on the debug data pin |
| ddata_out | output | 1 | Value the block drives onto the data pin |
| ddata_oe | output | 1 | Data pin output enable |
| dbg_lock_bit | input | 1 | Debug lock, 0 = locked |
| req_valid | output | 1 | One-cycle request strobe to the back-end |
| req_code | output | 5 | Operation code of the request |
| req_nargs | output | 2 | Number of argument bytes |
| req_args | output | 24 | Argument bytes, right aligned |
| rsp_data | input | 8 | Back-end reply, valid during `req_valid` |

## Verification
The hardest situations to reach are the moments just around mode changes. One is a reset low phase that carries exactly one or exactly three clock pulses. Another is a second low phase with no pulses, which closes an already open link. The bench reaches these by driving the reset and clock pins directly with counted pulse trains. After each one it sends a full reply-requesting command and checks that no request and no output enable appear. The lock filter is covered by a full sweep over both lock values, five codes, every argument count and both reply-flag values.

// File: rtl/dbg_link_pkg.sv
package dbg_link_pkg;
    localparam int BYTE_W    = 8;
    localparam int CODE_W    = 5;
    localparam int NARG_W    = 2;
    localparam int ARG_MAX   = (1 << NARG_W) - 1;
    localparam int ARG_W     = BYTE_W * ARG_MAX;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        S_OFF,
        S_ARM,
        S_CMD,
        S_ARG,
        S_ISSUE,
        S_RESP
    } state_t;

    localparam logic [CODE_W-1:0] OP_ERASE  = 5'h02;
    localparam logic [CODE_W-1:0] OP_STATUS = 5'h06;
    localparam logic [CODE_W-1:0] OP_ACCESS = 5'h0B;
    localparam logic [CODE_W-1:0] OP_CHIPID = 5'h0C;
endpackage

// File: rtl/dbg_sync.sv
module dbg_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= '0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dbg_cmd_gate.sv
module dbg_cmd_gate
    import dbg_link_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              unlocked,
    output logic              known,
    output logic              allowed,
    output logic              is_status
);
    logic whitelisted;

    always_comb begin
        known       = (code == OP_ERASE) || (code == OP_STATUS) ||
                      (code == OP_ACCESS) || (code == OP_CHIPID);
        whitelisted = (code == OP_ERASE) || (code == OP_STATUS) ||
                      (code == OP_CHIPID);
        allowed     = known && (unlocked || whitelisted);
        is_status   = (code == OP_STATUS);
    end
endmodule

// File: rtl/dbg_link_slave.sv
module dbg_link_slave
    import dbg_link_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_rst_n_pin,
    input  logic              dclk_pin,
    input  logic              ddata_in,
    output logic              ddata_out,
    output logic              ddata_oe,
    input  logic              dbg_lock_bit,
    output logic              req_valid,
    output logic [CODE_W-1:0] req_code,
    output logic [NARG_W-1:0] req_nargs,
    output logic [ARG_W-1:0]  req_args,
    input  logic [BYTE_W-1:0] rsp_data
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    logic hold_s, dclk_s, din_s, dclk_prev;
    logic rise_evt, fall_evt, last_bit;

    dbg_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({chip_rst_n_pin, dclk_pin, ddata_in}),
        .q    ({hold_s, dclk_s, din_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dclk_prev <= 1'b0;
        else        dclk_prev <= dclk_s;
    end

    assign rise_evt = dclk_s & ~dclk_prev;
    assign fall_evt = ~dclk_s & dclk_prev;

    state_t                state, nxt;
    logic [1:0]            ent_cnt;
    logic [BIT_CNT_W-1:0]  bit_cnt;
    logic [NARG_W-1:0]     arg_idx;
    logic [BYTE_W-1:0]     cmd_sh, cmd_q, rsp_sh, byte_now, rsp_fill;
    logic [ARG_W-1:0]      args_q;
    logic [CODE_W-1:0]     q_code;
    logic                  q_want;
    logic [NARG_W-1:0]     q_nargs;
    logic                  known, allowed, is_status;

    assign byte_now = {cmd_sh[BYTE_W-2:0], din_s};
    assign last_bit = fall_evt && (bit_cnt == LAST_BIT);
    assign q_code   = cmd_q[BYTE_W-1 -: CODE_W];
    assign q_want   = cmd_q[NARG_W];
    assign q_nargs  = cmd_q[NARG_W-1:0];

    dbg_cmd_gate u_gate (
        .code     (q_code),
        .unlocked (dbg_lock_bit),
        .known    (known),
        .allowed  (allowed),
        .is_status(is_status)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_OFF:   if (!hold_s) nxt = S_ARM;
            S_ARM:   if (hold_s) nxt = (ent_cnt == 2'd2) ? S_CMD : S_OFF;
            S_CMD:   if (last_bit) nxt = (byte_now[NARG_W-1:0] == '0) ? S_ISSUE : S_ARG;
            S_ARG:   if (last_bit && (arg_idx == q_nargs - NARG_W'(1))) nxt = S_ISSUE;
            S_ISSUE: nxt = q_want ? S_RESP : S_CMD;
            S_RESP:  if (last_bit) nxt = S_CMD;
            default: nxt = S_OFF;
        endcase
        if (state != S_OFF && state != S_ARM && !hold_s) nxt = S_ARM;
    end

    assign rsp_fill = !allowed  ? '0 :
                      is_status ? {rsp_data[BYTE_W-1:1], dbg_lock_bit} : rsp_data;

    // Datapath and pin outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_cnt   <= '0;
            bit_cnt   <= '0;
            arg_idx   <= '0;
            cmd_sh    <= '0;
            cmd_q     <= '0;
            args_q    <= '0;
            rsp_sh    <= '0;
            ddata_out <= 1'b0;
            ddata_oe  <= 1'b0;
        end else if (nxt == S_ARM && state != S_ARM) begin
            ent_cnt  <= '0;
            bit_cnt  <= '0;
            ddata_oe <= 1'b0;
        end else begin
            unique case (state)
                S_ARM: begin
                    if (rise_evt && ent_cnt != 2'd3) ent_cnt <= ent_cnt + 2'd1;
                    bit_cnt <= '0;
                end
                S_CMD: begin
                    if (fall_evt) begin
                        cmd_sh  <= byte_now;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (last_bit) begin
                            cmd_q   <= byte_now;
                            arg_idx <= '0;
                            args_q  <= '0;
                        end
                    end
                end
                S_ARG: begin
                    if (fall_evt) begin
                        args_q  <= {args_q[ARG_W-2:0], din_s};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (last_bit) arg_idx <= arg_idx + 1'b1;
                    end
                end
                S_ISSUE: begin
                    rsp_sh  <= rsp_fill;
                    bit_cnt <= '0;
                end
                S_RESP: begin
                    if (rise_evt) begin
                        ddata_out <= rsp_sh[BYTE_W-1];
                        rsp_sh    <= {rsp_sh[BYTE_W-2:0], 1'b0};
                        ddata_oe  <= 1'b1;
                    end
                    if (fall_evt) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        if (last_bit) ddata_oe <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Request port
    always_comb begin
        req_valid = (state == S_ISSUE) && allowed;
        req_code  = q_code;
        req_nargs = q_nargs;
        req_args  = args_q;
    end

    a_r2_closed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OFF || state == S_ARM) |-> (!ddata_oe && !req_valid));
    a_r6_oe_only_in_reply: assert property (@(posedge clk) disable iff (!rst_n)
        ddata_oe |-> (state == S_RESP));
    a_r6_out_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (ddata_oe && !rise_evt) |=> $stable(ddata_out));
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);
    a_r7_lock_whitelist: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !dbg_lock_bit) |->
        (req_code == OP_ERASE || req_code == OP_STATUS || req_code == OP_CHIPID));
    a_r8_blocked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ISSUE && hold_s && !allowed) |=> (rsp_sh == '0));
endmodule

// File: tb/dbg_link_slave_tb.sv
`timescale 1ns/1ps
module dbg_link_slave_tb_top;
    localparam int HALF = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_rst_n_pin = 1'b1;
    logic        dclk_pin = 1'b0;
    logic        host_d = 1'b0;
    logic        ddata_in, ddata_out, ddata_oe;
    logic        dbg_lock_bit = 1'b1;
    logic        req_valid;
    logic [4:0]  req_code;
    logic [1:0]  req_nargs;
    logic [23:0] req_args;
    logic [7:0]  rsp_data;

    int checks = 0;
    int fails  = 0;
    int req_cnt = 0;
    int oe_cnt  = 0;
    logic [4:0]  last_code;
    logic [1:0]  last_nargs;
    logic [23:0] last_args;

    always #5 clk = ~clk;

    assign ddata_in = ddata_oe ? ddata_out : host_d;

    function automatic logic [7:0] be_model(input logic [4:0] c, input logic [23:0] a);
        return ({3'b0, c} * 8'd7) ^ a[7:0] ^ 8'hA5;
    endfunction

    assign rsp_data = be_model(req_code, req_args);

    dbg_link_slave dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .chip_rst_n_pin(chip_rst_n_pin),
        .dclk_pin      (dclk_pin),
        .ddata_in      (ddata_in),
        .ddata_out     (ddata_out),
        .ddata_oe      (ddata_oe),
        .dbg_lock_bit  (dbg_lock_bit),
        .req_valid     (req_valid),
        .req_code      (req_code),
        .req_nargs     (req_nargs),
        .req_args      (req_args),
        .rsp_data      (rsp_data)
    );

    always @(posedge clk) begin
        if (req_valid) begin
            req_cnt    <= req_cnt + 1;
            last_code  <= req_code;
            last_nargs <= req_nargs;
            last_args  <= req_args;
        end
        if (ddata_oe) oe_cnt <= oe_cnt + 1;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic enter(input int edges);
        chip_rst_n_pin = 1'b0;
        #200;
        for (int e = 0; e < edges; e++) begin
            dclk_pin = 1'b1; #HALF;
            dclk_pin = 1'b0; #HALF;
        end
        #100;
        chip_rst_n_pin = 1'b1;
        #200;
    endtask

    // R5: host presents each bit MSB first; target samples at the falling edge
    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            host_d   = b[i];
            dclk_pin = 1'b1; #HALF;
            dclk_pin = 1'b0; #HALF;
        end
    endtask

    task automatic read_byte(output logic [7:0] b, output bit oe_ok);
        oe_ok = 1'b1;
        b = '0;
        for (int i = 7; i >= 0; i--) begin
            dclk_pin = 1'b1; #55;
            b[i] = ddata_in;
            if (!ddata_oe) oe_ok = 1'b0;
            #(HALF - 55);
            dclk_pin = 1'b0; #HALF;
        end
    endtask

    function automatic bit is_known(input logic [4:0] c);
        return c == 5'h02 || c == 5'h06 || c == 5'h0B || c == 5'h0C;
    endfunction

    task automatic run_cmd(input logic [4:0] code, input bit want, input int n,
                           input bit lock, input bit active, input string rq);
        logic [7:0]  cb, rb, exp_rsp;
        logic [23:0] ea;
        int c0, o0;
        bit ook, allowed, iss;
        dbg_lock_bit = lock;
        cb = {code, want, 2'(n)};
        ea = '0;
        c0 = req_cnt;
        o0 = oe_cnt;
        rb = '0;
        ook = 1'b1;
        send_byte(cb);
        for (int k = 0; k < n; k++) begin
            logic [7:0] ab;
            ab = 8'h3C + 8'(17 * k) + {3'b0, code};
            ea = {ea[15:0], ab};
            send_byte(ab);
        end
        if (want) read_byte(rb, ook);
        else #(HALF * 4);
        #(HALF * 2);
        allowed = is_known(code) &&
                  (lock || code == 5'h02 || code == 5'h06 || code == 5'h0C);
        iss = active && allowed;
        if (!active) begin
            chk(req_cnt == c0, rq, "request while closed", req_cnt - c0, 0);
            chk(oe_cnt == o0, rq, "oe while closed", oe_cnt - o0, 0);
        end else begin
            // R7 lock filter, R8 unknown codes, R10 exactly one pulse
            chk(req_cnt - c0 == (iss ? 1 : 0),
                !is_known(code) ? "R8" : (!allowed ? "R7" : "R10"),
                "request count", req_cnt - c0, iss ? 1 : 0);
            if (iss) begin
                chk(last_code == code, "R4", "code", last_code, code);
                chk(last_nargs == 2'(n), "R4", "nargs", last_nargs, n);
                chk(last_args == ea, "R5", "args", last_args, ea);
            end
            if (want) begin
                exp_rsp = !iss ? 8'h00 :
                          (code == 5'h06) ? {be_model(code, ea)[7:1], lock} :
                          be_model(code, ea);
                chk(rb == exp_rsp, (code == 5'h06 && iss) ? "R9" : (iss ? "R6" : "R8"),
                    "reply byte", rb, exp_rsp);
                chk(ook, "R6", "oe during reply", 0, 1);
                chk(ddata_oe == 1'b0, "R6", "oe after reply", ddata_oe, 0);
            end else begin
                chk(oe_cnt == o0, "R11", "oe without reply", oe_cnt - o0, 0);
            end
        end
    endtask

    initial begin
        #1_500_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [4:0] codes [5];
        codes[0] = 5'h02; codes[1] = 5'h06; codes[2] = 5'h0C;
        codes[3] = 5'h0B; codes[4] = 5'h11;
        repeat (10) @(posedge clk);
        rst_n = 1'b1;
        #3;
        chk(ddata_oe == 1'b0 && req_valid == 1'b0, "R2", "reset state",
            {ddata_oe, req_valid}, 0);
        #200;
        // R2: no entry sequence at all
        run_cmd(5'h0C, 1'b1, 1, 1'b1, 1'b0, "R2");
        // R1: one and three edges do not open the link
        enter(1);
        run_cmd(5'h0C, 1'b1, 2, 1'b1, 1'b0, "R1");
        enter(3);
        run_cmd(5'h06, 1'b1, 0, 1'b1, 1'b0, "R1");
        // R1: exactly two edges open it; full sweep R4..R11
        enter(2);
        for (int lk = 0; lk < 2; lk++)
            for (int ci = 0; ci < 5; ci++)
                for (int n = 0; n < 4; n++)
                    for (int w = 0; w < 2; w++)
                        run_cmd(codes[ci], w[0], n, lk[0], 1'b1, "R1");
        // R3: reset low phase without edges closes the link
        enter(0);
        run_cmd(5'h0C, 1'b1, 1, 1'b1, 1'b0, "R3");
        run_cmd(5'h02, 1'b0, 0, 1'b1, 1'b0, "R3");
        // R1: reopen and confirm it works again
        enter(2);
        run_cmd(5'h0B, 1'b1, 3, 1'b1, 1'b1, "R1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule